// File: doc/BRIEF.md
# Receive Queue Indirection Table

This block holds the table that steers received packets to receive queues. A hash engine upstream produces a value for each packet. The low seven bits of that value index a 128-entry table of 8-bit entries, and the block returns the selected entry together with the 2-bit queue number taken from it. Software loads and updates the table through a simple register bus. Each 32-bit register carries four consecutive entries, and per-byte enables allow a single entry to be rewritten without a read-modify-write.

A 3-bit receive-queue mode input stands in for the queue-enable control field. In the two pooled modes, a per-lookup pool-select input chooses which of two 2-bit fields in the entry supplies the queue number. In every other mode the upper field is used. The table is not cleared by reset, so software must fill it before queueing is enabled. Table updates are not aligned to packet boundaries.

Top module: `rss_reta`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `reg_rd_valid` and `lk_out_valid` are 0.
- R2: A write to byte address 0x5C00 + 4*n (n = 0..31) with all four byte enables stores `reg_wdata[8k+7:8k]` as table entry 4*n + k. A later read of that address returns the four entries in the same lanes, and a lookup of index 4*n + k returns that byte on `lk_entry`.
- R3: A write updates only the entries whose `reg_be[k]` bit is 1. Entries in lanes with a 0 enable keep their previous value.
- R4: A read strobe produces `reg_rd_valid` = 1 and the read data exactly one cycle later. In every other cycle `reg_rd_valid` is 0.
- R5: The address decode ignores `reg_addr[1:0]`. A write whose address lies outside 0x5C00..0x5C7F changes no entry. A read outside that window returns all zeros.
- R6: `lk_out_valid` equals `lk_valid` delayed by one cycle, and `lk_entry`/`lk_queue` belong to the index presented in that earlier cycle.
- R7: When `rxq_mode` is neither 3'b101 nor 3'b110, `lk_queue` is entry bits 7:6, whatever the value of `lk_pool_sel`.
- R8: When `rxq_mode` is 3'b101 or 3'b110, `lk_queue` is entry bits 3:2 if `lk_pool_sel` = 0, and entry bits 7:6 if `lk_pool_sel` = 1.
- R9: Entry bits 5:4 and 1:0 are stored and read back exactly as written, and they have no effect on `lk_queue`.
- R10: A lookup issued in the same cycle as a write to its entry returns the value held before that write. The write is visible to lookups from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_be | input | 4 | Byte enables for writes |
| reg_rd_valid | output | 1 | Read data valid, one cycle after the read strobe |
| reg_rdata | output | 32 | Read data |
| rxq_mode | input | 3 | Receive-queue mode; 101b and 110b select pooled operation |
| lk_valid | input | 1 | Lookup request strobe |
| lk_index | input | 7 | Table index (low hash bits) |
| lk_pool_sel | input | 1 | Pool choice in pooled modes (0 = bits 3:2, 1 = bits 7:6) |
| lk_out_valid | output | 1 | Lookup result valid |
| lk_queue | output | 2 | Selected queue number |
| lk_entry | output | 8 | Full table entry |

## Verification
The bench goes after the lane-to-entry mapping first. A design that swapped byte lanes or misplaced the word index would return the right data for the wrong index, so every one of the 128 entries is loaded with a distinct value and looked up. Partial byte-enable writes and writes just outside the window at both ends catch a decoder that clobbers neighbouring entries or aliases addresses. All eight modes are swept with both pool choices, and entries with only reserved bits set expose a selector that takes the wrong field. A lookup that collides with a write to its own entry separates a table with write-through from one that returns the stored value, which is what R10 requires.

// File: rtl/rss_reta_pkg.sv
package rss_reta_pkg;

   localparam int MODE_W = 3;

   // Modes in which the pool-select input chooses the queue field
   localparam logic [MODE_W-1:0] MODE_POOLED_A = 3'b101;
   localparam logic [MODE_W-1:0] MODE_POOLED_B = 3'b110;

   function automatic logic mode_is_pooled(input logic [MODE_W-1:0] m);
      return (m == MODE_POOLED_A) || (m == MODE_POOLED_B);
   endfunction

endpackage

// File: rtl/rss_reta_store.sv
module rss_reta_store #(
   parameter int ENTRIES = 128,
   parameter int ENTRY_W = 8,
   parameter int BUS_W   = 32,
   localparam int LANES  = BUS_W / ENTRY_W,
   localparam int WORDS  = ENTRIES / LANES,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int WIDX_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [WIDX_W-1:0] wr_word,
   input  logic [BUS_W-1:0]  wr_data,
   input  logic [LANES-1:0]  wr_be,
   input  logic [WIDX_W-1:0] rd_word,
   output logic [BUS_W-1:0]  rd_data,
   input  logic [IDX_W-1:0]  lk_index,
   output logic [ENTRY_W-1:0] lk_entry
);

   if (BUS_W % ENTRY_W != 0) begin : g_bad_lane
      $error("rss_reta_store: bus width must be a multiple of entry width");
   end
   if (ENTRIES % LANES != 0) begin : g_bad_depth
      $error("rss_reta_store: entry count must fill whole words");
   end

   // Storage is deliberately not reset: software loads it before use
   logic [ENTRY_W-1:0] mem [ENTRIES];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int k = 0; k < LANES; k++) begin
            if (wr_be[k]) begin
               mem[IDX_W'(int'(wr_word) * LANES + k)] <= wr_data[k*ENTRY_W +: ENTRY_W];
            end
         end
      end
   end

   // Register-side read: one lane per entry of the addressed word
   for (genvar k = 0; k < LANES; k++) begin : g_rd_lane
      assign rd_data[k*ENTRY_W +: ENTRY_W] = mem[IDX_W'(int'(rd_word) * LANES + k)];
   end

   assign lk_entry = mem[lk_index];

endmodule

// File: rtl/rss_reta_qsel.sv
module rss_reta_qsel
   import rss_reta_pkg::*;
#(
   parameter int ENTRY_W  = 8,
   parameter int QUEUE_W  = 2,
   parameter int DEF_LSB  = 6,
   parameter int POOL_LSB = 2
) (
   input  logic [ENTRY_W-1:0] entry,
   input  logic [MODE_W-1:0]  mode,
   input  logic               pool_sel,
   output logic [QUEUE_W-1:0] queue
);

   if (DEF_LSB + QUEUE_W > ENTRY_W || POOL_LSB + QUEUE_W > ENTRY_W) begin : g_bad_field
      $error("rss_reta_qsel: queue field lies outside the entry");
   end

   logic [QUEUE_W-1:0] def_field;
   logic [QUEUE_W-1:0] pool_field;

   assign def_field  = entry[DEF_LSB  +: QUEUE_W];
   assign pool_field = entry[POOL_LSB +: QUEUE_W];

   always_comb begin
      if (mode_is_pooled(mode) && !pool_sel) queue = pool_field;
      else                                   queue = def_field;
   end

   // Bits outside both queue fields are reserved and never steer the result
   logic unused_entry_bits;
   assign unused_entry_bits = ^entry;

endmodule

// File: rtl/rss_reta.sv
module rss_reta
   import rss_reta_pkg::*;
#(
   parameter int ENTRIES   = 128,
   parameter int ENTRY_W   = 8,
   parameter int BUS_W     = 32,
   parameter int ADDR_W    = 16,
   parameter int BASE_ADDR = 'h5C00,
   parameter int QUEUE_W   = 2,
   parameter int DEF_LSB   = 6,
   parameter int POOL_LSB  = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      reg_wr_en,
   input  logic                      reg_rd_en,
   input  logic [ADDR_W-1:0]         reg_addr,
   input  logic [BUS_W-1:0]          reg_wdata,
   input  logic [BUS_W/8-1:0]        reg_be,
   output logic                      reg_rd_valid,
   output logic [BUS_W-1:0]          reg_rdata,
   input  logic [2:0]                rxq_mode,
   input  logic                      lk_valid,
   input  logic [$clog2(ENTRIES)-1:0] lk_index,
   input  logic                      lk_pool_sel,
   output logic                      lk_out_valid,
   output logic [QUEUE_W-1:0]        lk_queue,
   output logic [ENTRY_W-1:0]        lk_entry
);

   localparam int LANES       = BUS_W / ENTRY_W;
   localparam int WORDS       = ENTRIES / LANES;
   localparam int IDX_W       = $clog2(ENTRIES);
   localparam int WIDX_W      = $clog2(WORDS);
   localparam int BYTE_OFS_W  = $clog2(BUS_W / 8);
   localparam int WIN_BYTES   = WORDS * (BUS_W / 8);
   localparam int WIN_W       = $clog2(WIN_BYTES);
   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);

   if (ENTRY_W != 8) begin : g_bad_entry
      $error("rss_reta: byte enables require byte-wide entries");
   end
   if (BASE_ADDR % WIN_BYTES != 0) begin : g_bad_base
      $error("rss_reta: base address must be aligned to the window size");
   end
   if (WIN_W + 1 > ADDR_W) begin : g_bad_addr
      $error("rss_reta: address too narrow for the table window");
   end

   // Address decode
   logic              win_hit;
   logic [WIDX_W-1:0] word_sel;
   logic              unused_addr_bits;

   assign win_hit          = (reg_addr[ADDR_W-1:WIN_W] == BASE_V[ADDR_W-1:WIN_W]);
   assign word_sel         = reg_addr[WIN_W-1:BYTE_OFS_W];
   assign unused_addr_bits = ^reg_addr[BYTE_OFS_W-1:0];

   logic [BUS_W-1:0]   word_rd;
   logic [ENTRY_W-1:0] entry_rd;
   logic [QUEUE_W-1:0] queue_sel;

   rss_reta_store #(
      .ENTRIES (ENTRIES),
      .ENTRY_W (ENTRY_W),
      .BUS_W   (BUS_W)
   ) store_i (
      .clk      (clk),
      .wr_en    (reg_wr_en && win_hit),
      .wr_word  (word_sel),
      .wr_data  (reg_wdata),
      .wr_be    (reg_be),
      .rd_word  (word_sel),
      .rd_data  (word_rd),
      .lk_index (lk_index),
      .lk_entry (entry_rd)
   );

   rss_reta_qsel #(
      .ENTRY_W  (ENTRY_W),
      .QUEUE_W  (QUEUE_W),
      .DEF_LSB  (DEF_LSB),
      .POOL_LSB (POOL_LSB)
   ) qsel_i (
      .entry    (entry_rd),
      .mode     (rxq_mode),
      .pool_sel (lk_pool_sel),
      .queue    (queue_sel)
   );

   // Register-side read pipeline
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rd_valid <= 1'b0;
         reg_rdata    <= '0;
      end else begin
         reg_rd_valid <= reg_rd_en;
         if (reg_rd_en) reg_rdata <= win_hit ? word_rd : '0;
      end
   end

   // Lookup pipeline: table sampled before any same-cycle write lands
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk_out_valid <= 1'b0;
         lk_queue     <= '0;
         lk_entry     <= '0;
      end else begin
         lk_out_valid <= lk_valid;
         if (lk_valid) begin
            lk_queue <= queue_sel;
            lk_entry <= entry_rd;
         end
      end
   end

   assert_rd_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_valid == $past(reg_rd_en));

   assert_rd_outside_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_en && !win_hit) |=> (reg_rdata == '0));

   assert_lk_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lk_out_valid == $past(lk_valid));

   assert_default_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !mode_is_pooled(rxq_mode)) |=> (lk_queue == lk_entry[DEF_LSB +: QUEUE_W]));

   assert_pool_field_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && mode_is_pooled(rxq_mode) && !lk_pool_sel) |=> (lk_queue == lk_entry[POOL_LSB +: QUEUE_W]));

endmodule

// File: tb/rss_reta_tb_top.sv
`timescale 1ns/1ps
module rss_reta_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic        reg_rd_en = 1'b0;
   logic [15:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [3:0]  reg_be = '0;
   logic        reg_rd_valid;
   logic [31:0] reg_rdata;
   logic [2:0]  rxq_mode = '0;
   logic        lk_valid = 1'b0;
   logic [6:0]  lk_index = '0;
   logic        lk_pool_sel = 1'b0;
   logic        lk_out_valid;
   logic [1:0]  lk_queue;
   logic [7:0]  lk_entry;

   always #2 clk = ~clk;

   rss_reta dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_wr_en    (reg_wr_en),
      .reg_rd_en    (reg_rd_en),
      .reg_addr     (reg_addr),
      .reg_wdata    (reg_wdata),
      .reg_be       (reg_be),
      .reg_rd_valid (reg_rd_valid),
      .reg_rdata    (reg_rdata),
      .rxq_mode     (rxq_mode),
      .lk_valid     (lk_valid),
      .lk_index     (lk_index),
      .lk_pool_sel  (lk_pool_sel),
      .lk_out_valid (lk_out_valid),
      .lk_queue     (lk_queue),
      .lk_entry     (lk_entry)
   );

   int vectors = 0;
   int fails   = 0;
   int model [128];

   function automatic int ref_queue(int e, int md, bit ps);
      if ((md == 5 || md == 6) && !ps) return (e >> 2) & 3;
      return (e >> 6) & 3;
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // One clock of stimulus; the model predicts the outputs after the edge
   task automatic cyc(bit we, bit re, int a, logic [31:0] d, logic [3:0] be,
                      bit lv, int li, bit ps, int md, string tag);
      bit          hit;
      int          w;
      int          e_ent;
      int          e_q;
      logic [31:0] e_rd;
      hit   = ((a >> 7) == ('h5C00 >> 7));
      w     = (a >> 2) & 31;
      e_ent = model[li & 127];
      e_q   = ref_queue(e_ent, md, ps);
      e_rd  = hit ? {8'(model[4*w+3]), 8'(model[4*w+2]), 8'(model[4*w+1]), 8'(model[4*w])} : 32'h0;
      if (we && hit) begin
         for (int k = 0; k < 4; k++) if (be[k]) model[4*w+k] = int'(d[8*k +: 8]);
      end
      reg_wr_en   = we;
      reg_rd_en   = re;
      reg_addr    = 16'(a);
      reg_wdata   = d;
      reg_be      = be;
      lk_valid    = lv;
      lk_index    = 7'(li);
      lk_pool_sel = ps;
      rxq_mode    = 3'(md);
      @(posedge clk);
      @(negedge clk);
      check("R4", "rd_valid", int'(reg_rd_valid), int'(re));
      if (re) check(tag, "rdata", int'(reg_rdata), int'(e_rd));
      check("R6", "lk_out_valid", int'(lk_out_valid), int'(lv));
      if (lv) begin
         check(tag, "lk_entry", int'(lk_entry), e_ent);
         check(tag, "lk_queue", int'(lk_queue), e_q);
      end
   endtask

   task automatic wr(int a, logic [31:0] d, logic [3:0] be, string tag);
      cyc(1'b1, 1'b0, a, d, be, 1'b0, 0, 1'b0, 0, tag);
   endtask

   task automatic rd(int a, string tag);
      cyc(1'b0, 1'b1, a, 32'h0, 4'h0, 1'b0, 0, 1'b0, 0, tag);
   endtask

   task automatic lk(int li, bit ps, int md, string tag);
      cyc(1'b0, 1'b0, 0, 32'h0, 4'h0, 1'b1, li, ps, md, tag);
   endtask

   bit done = 1'b0;

   initial begin
      #400000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 128; i++) model[i] = 0;
      repeat (3) @(negedge clk);
      check("R1", "rd_valid in reset", int'(reg_rd_valid), 0);
      check("R1", "lk_out_valid in reset", int'(lk_out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "rd_valid after reset", int'(reg_rd_valid), 0);
      check("R1", "lk_out_valid after reset", int'(lk_out_valid), 0);

      // R2: load every entry with a distinct value, low address bits varied
      for (int n = 0; n < 32; n++) begin
         logic [31:0] d;
         for (int k = 0; k < 4; k++) d[8*k +: 8] = 8'(((4*n + k) * 37 + 11) & 255);
         wr('h5C00 + 4*n + (n & 3), d, 4'hF, "R2");
      end
      for (int n = 0; n < 32; n++) rd('h5C00 + 4*n, "R2");
      for (int i = 0; i < 128; i++) lk(i, i[0], 0, "R2");

      // R7 / R8: all modes, both pool choices
      for (int md = 0; md < 8; md++) begin
         for (int i = 0; i < 16; i++) begin
            lk(i * 7 + md, 1'b0, md, (md == 5 || md == 6) ? "R8" : "R7");
            lk(i * 7 + md, 1'b1, md, (md == 5 || md == 6) ? "R8" : "R7");
         end
      end

      // R3: single-lane and two-lane writes
      wr('h5C14, 32'hAABBCCDD, 4'b0100, "R3");
      rd('h5C14, "R3");
      for (int i = 20; i < 24; i++) lk(i, 1'b1, 0, "R3");
      wr('h5C7C, 32'h12345678, 4'b1001, "R3");
      rd('h5C7C, "R3");

      // R5: writes just outside the window change nothing; reads there give zero
      wr('h5C80, 32'hFFFFFFFF, 4'hF, "R5");
      wr('h5BFC, 32'hFFFFFFFF, 4'hF, "R5");
      wr('h1C00, 32'hFFFFFFFF, 4'hF, "R5");
      rd('h5C80, "R5");
      rd('h5BFC, "R5");
      rd('h5C00, "R5");
      rd('h5C7C, "R5");
      lk(0, 1'b1, 0, "R5");
      lk(127, 1'b1, 0, "R5");

      // R9: reserved bits stored, read back, and never steer the queue
      wr('h5C00, 32'h00CC_0033, 4'hF, "R9");
      rd('h5C00, "R9");
      for (int md = 0; md < 8; md++) begin
         lk(0, 1'b0, md, "R9");
         lk(0, 1'b1, md, "R9");
         lk(2, 1'b0, md, "R9");
         lk(2, 1'b1, md, "R9");
      end

      // R10: lookup colliding with a write to its own entry sees the old value
      cyc(1'b1, 1'b0, 'h5C08, 32'h8040C0FF, 4'hF, 1'b1, 9, 1'b0, 5, "R10");
      lk(9, 1'b0, 5, "R10");
      cyc(1'b1, 1'b1, 'h5C08, 32'h0, 4'h2, 1'b1, 9, 1'b1, 6, "R10");
      lk(9, 1'b1, 6, "R10");
      rd('h5C08, "R10");

      // R4 / R6: idle cycles keep both valids low
      cyc(1'b0, 1'b0, 0, 32'h0, 4'h0, 1'b0, 0, 1'b0, 0, "R6");
      cyc(1'b0, 1'b0, 0, 32'h0, 4'h0, 1'b0, 0, 1'b0, 0, "R4");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule